// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table as three arrays of 8-bit components (red, green, blue) and fills it through a small 32-bit register window. Software first writes a starting entry number to the index register. It then writes colour components one after another to the colour register. An internal phase counter routes each component to red, green or blue in turn. After the blue component, the counter moves the entry number on by one, so a whole table can be streamed in with one index write.

A separate lookup port serves the pixel pipeline. An entry number presented with a valid strobe returns that entry's RGB triple one cycle later. The port has no ready signal: the block accepts a request on every cycle and the consumer must take each result in the cycle it appears, so there is no back-pressure.

When a stored component actually changes value, a one-cycle update pulse reports the entry number, so that downstream colour caches can refresh only that entry. Register reads have no side effect and return zero.

Top module: `clut_loader`

## Requirements
- R1: A write with `bus_addr[3:2]` = 0 loads the current entry number from `bus_wdata[31:24]` and sets the component phase to red. This holds even in the middle of a red/green/blue sequence.
- R2: A write with `bus_addr[3:2]` = 1 stores `bus_wdata[31:24]` into the component that the current phase selects, in the order red, green, blue. `bus_wdata[23:0]` and `bus_addr[1:0]` are ignored.
- R3: The store of a blue component increments the entry number by one, wrapping from 255 to 0, and returns the phase to red.
- R4: Writes with `bus_addr[3:2]` = 2 or 3 change neither the table, the entry number nor the phase.
- R5: `bus_rdata` reads as zero at all times.
- R6: After reset, every entry reads as 0x000000 except entry 255, which reads as 0xFFFFFF. The entry number and the phase are both cleared to zero and red.
- R7: `upd_valid` pulses for exactly one cycle, in the cycle after a component store that changes the stored value, and `upd_index` then carries that entry. A store of a value equal to the one already held raises no pulse.
- R8: A lookup with `lk_valid` high returns `out_valid` high and `out_rgb` = {red, green, blue} of `lk_index` in the next cycle. If a store to the same entry happens at the same clock edge, the lookup returns the contents from before that store. `out_valid` is low in the cycle after a cycle without `lk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address within the 16-byte register window |
| bus_wdata | input | 32 | Write data; the field used is bits 31:24 |
| bus_rdata | output | 32 | Register read data, always zero |
| lk_valid | input | 1 | Lookup request valid |
| lk_index | input | 8 | Entry to look up |
| out_valid | output | 1 | Lookup result valid, one cycle after the request |
| out_rgb | output | 24 | Looked-up colour: red 23:16, green 15:8, blue 7:0 |
| upd_valid | output | 1 | One-cycle pulse: an entry's contents changed |
| upd_index | output | 8 | Entry that changed, valid with upd_valid |

## Verification
The table is loaded in several ways. One is a single triple after an index write, which shows whether the component order is correct. Another is a run of two triples, which shows whether auto-increment works or the last entry is overwritten. A third is a triple written at entry 255, which shows wrap-around as distinct from saturation. A sequence cut short by an index write shows whether the phase restarts or carries over. Writes to the unused words and components with busy low bytes must leave later loads unchanged. Rewriting an equal value must leave the update pulse low, which separates change detection from a plain write strobe.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam logic [1:0] WORD_INDEX = 2'd0;
  localparam logic [1:0] WORD_COLOR = 2'd1;
  localparam int         NUM_COMP   = 3;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_word,
  input  logic [7:0]       wr_field,
  output logic             st_en,
  output phase_t           st_comp,
  output logic [IDX_W-1:0] st_idx
);
  logic [IDX_W-1:0] idx_q;
  phase_t           phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (wr_en) begin
      case (wr_word)
        WORD_INDEX: begin
          idx_q   <= wr_field[IDX_W-1:0];
          phase_q <= PH_RED;
        end
        WORD_COLOR: begin
          case (phase_q)
            PH_RED:  phase_q <= PH_GRN;
            PH_GRN:  phase_q <= PH_BLU;
            default: begin
              phase_q <= PH_RED;
              idx_q   <= idx_q + 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign st_en   = wr_en && (wr_word == WORD_COLOR);
  assign st_comp = phase_q;
  assign st_idx  = idx_q;

  // R1: an index write restarts the component sequence
  a_r1_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == WORD_INDEX) |=> (phase_q == PH_RED && idx_q == $past(wr_field[IDX_W-1:0])));

  // R3: blue store advances the entry with wrap
  a_r3_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && phase_q == PH_BLU) |=> (idx_q == IDX_W'($past(idx_q) + 1) && phase_q == PH_RED));

  // R4: writes to the unused words leave the sequencer alone
  a_r4_unused_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[1]) |=> ($stable(idx_q) && $stable(phase_q)));

  // R2: the phase never leaves its three legal values
  a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != phase_t'(2'd3));
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  output logic          changed,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i == DEPTH - 1) ? {W{1'b1}} : '0;
      end
      rdata <= '0;
    end else begin
      rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
    end
  end

  assign changed = we && (mem[waddr] != wdata);

  // R2: a store lands in the addressed entry
  a_r2_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 8,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int FIELD_LSB = DATA_W - 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr_en,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     lk_valid,
  input  logic [IDX_W-1:0]         lk_index,
  output logic                     out_valid,
  output logic [NUM_COMP*COMP_W-1:0] out_rgb,
  output logic                     upd_valid,
  output logic [IDX_W-1:0]         upd_index
);
  logic             st_en;
  phase_t           st_comp;
  logic [IDX_W-1:0] st_idx;
  logic [7:0]       field;
  logic [NUM_COMP-1:0] comp_changed;
  logic [COMP_W-1:0]   comp_rd [NUM_COMP];
  logic             unused_bits;

  assign field       = bus_wdata[DATA_W-1:FIELD_LSB];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[FIELD_LSB-1:0]};
  assign bus_rdata   = '0;

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .wr_word  (bus_addr[3:2]),
    .wr_field (field),
    .st_en    (st_en),
    .st_comp  (st_comp),
    .st_idx   (st_idx)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    clut_bank #(.DEPTH(ENTRIES), .W(COMP_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_en && (st_comp == phase_t'(c))),
      .waddr   (st_idx),
      .wdata   (field[COMP_W-1:0]),
      .changed (comp_changed[c]),
      .raddr   (lk_index),
      .rdata   (comp_rd[c])
    );
    assign out_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] = comp_rd[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_index <= '0;
      out_valid <= 1'b0;
    end else begin
      upd_valid <= |comp_changed;
      upd_index <= st_idx;
      out_valid <= lk_valid;
    end
  end

  // R7: only one component bank can change per cycle
  a_r7_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_changed));

  // R7: a pulse follows a colour-word write
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(bus_wr_en && bus_addr[3:2] == WORD_COLOR));

  // R8: results appear only for a request one cycle earlier
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(lk_valid));

  // R5: reads never return data
  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |=> (bus_rdata == '0));
endmodule

// File: tb/clut_loader_tb.sv
module clut_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_index = '0;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic        upd_valid;
  logic [7:0]  upd_index;

  int checks = 0;
  int errors = 0;
  logic       last_upd;
  logic [7:0] last_upd_idx;
  logic [23:0] got_rgb;
  logic        got_valid;

  always #2.5 clk = ~clk;

  clut_loader u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_valid(lk_valid),
    .lk_index(lk_index), .out_valid(out_valid), .out_rgb(out_rgb),
    .upd_valid(upd_valid), .upd_index(upd_index)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
    last_upd = upd_valid; last_upd_idx = upd_index;
  endtask

  task automatic lookup(input logic [7:0] i);
    @(negedge clk);
    lk_valid = 1'b1; lk_index = i;
    @(negedge clk);
    lk_valid = 1'b0;
    got_valid = out_valid; got_rgb = out_rgb;
  endtask

  task automatic set_index(input logic [7:0] i);
    wr(4'h0, {i, 24'h0});
  endtask

  task automatic put(input logic [7:0] v);
    wr(4'h4, {v, 24'h0});
  endtask

  task automatic t_reset();
    lookup(8'd0);   chk("R6 entry0", {8'h0, got_rgb}, 32'h0);
    chk("R8 valid", {31'h0, got_valid}, 32'h1);
    lookup(8'd100); chk("R6 entry100", {8'h0, got_rgb}, 32'h0);
    lookup(8'd255); chk("R6 entry255", {8'h0, got_rgb}, 32'h00FFFFFF);
    chk("R5 rdata", bus_rdata, 32'h0);
    // R6: entry number cleared, so first triple lands at entry 0
    put(8'h01); put(8'h02); put(8'h03);
    lookup(8'd0); chk("R6 index zero", {8'h0, got_rgb}, 32'h00010203);
  endtask

  task automatic t_single();
    set_index(8'd10);
    put(8'h11);
    chk("R7 pulse", {31'h0, last_upd}, 32'h1);
    chk("R7 index", {24'h0, last_upd_idx}, 32'd10);
    wr(4'h4, 32'h22ABCDEF);   // R2: low bytes ignored
    put(8'h33);
    lookup(8'd10); chk("R2 order", {8'h0, got_rgb}, 32'h00112233);
    chk("R5 rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_autoinc();
    put(8'h44); put(8'h55); put(8'h66);
    lookup(8'd11); chk("R3 increment", {8'h0, got_rgb}, 32'h00445566);
    lookup(8'd10); chk("R3 previous kept", {8'h0, got_rgb}, 32'h00112233);
  endtask

  task automatic t_wrap();
    set_index(8'd255);
    put(8'h0A); put(8'h0B); put(8'h0C);
    put(8'h7A); put(8'h7B); put(8'h7C);
    lookup(8'd255); chk("R3 last entry", {8'h0, got_rgb}, 32'h000A0B0C);
    lookup(8'd0);   chk("R3 wrap", {8'h0, got_rgb}, 32'h007A7B7C);
  endtask

  task automatic t_restart();
    set_index(8'd20);
    put(8'hAA); put(8'hBB);
    set_index(8'd21);
    put(8'hCC);
    lookup(8'd20); chk("R1 partial", {8'h0, got_rgb}, 32'h00AABB00);
    lookup(8'd21); chk("R1 restart red", {8'h0, got_rgb}, 32'h00CC0000);
  endtask

  task automatic t_ignored();
    set_index(8'd30);
    put(8'h01);
    wr(4'h8, 32'h55000000);
    wr(4'hC, 32'h66000000);
    chk("R4 no pulse", {31'h0, last_upd}, 32'h0);
    lookup(8'd30); chk("R4 table kept", {8'h0, got_rgb}, 32'h00010000);
    put(8'h02); put(8'h03);
    lookup(8'd30); chk("R4 phase kept", {8'h0, got_rgb}, 32'h00010203);
  endtask

  task automatic t_same_value();
    set_index(8'd30);
    put(8'h01);
    chk("R7 equal no pulse", {31'h0, last_upd}, 32'h0);
    put(8'h09);
    chk("R7 change pulse", {31'h0, last_upd}, 32'h1);
    @(negedge clk);
    chk("R7 one cycle", {31'h0, upd_valid}, 32'h0);
  endtask

  task automatic t_latency();
    set_index(8'd40);
    put(8'h10); put(8'h20);
    // same-edge lookup and blue store: old contents returned
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h30000000;
    lk_valid = 1'b1; lk_index = 8'd40;
    @(negedge clk);
    bus_wr_en = 1'b0; lk_valid = 1'b0;
    chk("R8 old value", {8'h0, out_rgb}, 32'h00102000);
    chk("R8 valid", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    chk("R8 idle", {31'h0, out_valid}, 32'h0);
    lookup(8'd40); chk("R8 new value", {8'h0, out_rgb}, 32'h00102030);
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 upd idle", {31'h0, upd_valid}, 32'h0);
    t_reset();
    t_single();
    t_autoinc();
    t_wrap();
    t_restart();
    t_ignored();
    t_same_value();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule